// File: doc/BRIEF.md
# Power-Management Event Register and SCI Generator

This block keeps the power-management event state of a chipset and turns it into a level-sensitive system control interrupt (SCI). Two 16-bit registers can be reached through a 64-byte I/O window: an event status register and an event enable register. Software moves the window by programming a base address and switches decoding on or off, and both settings come in on configuration inputs. Event sources pulse for one cycle to set their status bits. Software clears status bits by writing ones. The SCI is high while any enabled source is pending, or while the hotplug bit of the general-purpose event block is both pending and enabled.

A separate APM command port accepts byte commands. One command code turns on the SCI-enable control bit and another turns it off. When the configuration allows it, every command also sends out a one-cycle SMI pulse. A timer-arm output tells the external timer block when an overflow event may be scheduled.

Top module: `pm_event_sci`

## Requirements
- R1: After reset, every status bit, every enable bit, the SCI-enable control bit, `sci`, `smi` and `tmr_arm` are 0.
- R2: A one-cycle pulse on `tmr_ovf_set`, `gbl_lock_set`, `pwrdn_req` or `rtc_set` sets status bit 0, 5, 8 or 10 respectively at the next clock edge. All other status bits always read 0.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set pulse arrives in the same cycle as a clear of the same bit, the bit stays set.
- R4: Status occupies window offsets 0 (low byte) and 1 (high byte). Enable occupies offsets 2 (low byte) and 3 (high byte). An access of `io_size` bytes (1 to 4, larger values treated as 4) at offset o carries offset o+k in data byte k. Data bytes outside the access read 0.
- R5: Reads of offsets 4 and above return 0, and writes to them change no register.
- R6: An access hits only when `cfg_decode_en` is 1 and `io_addr & 16'hFFC0` equals `cfg_io_base & 16'hFFC0`. A miss drives `io_hit` and `io_rdata` to 0 and writes nothing.
- R7: One cycle after status AND enable has any of bits 0, 5, 8 or 10 set, `sci` is 1.
- R8: One cycle after `gpe_hp_sts` and `gpe_hp_en` are both 1, `sci` is 1. When neither R7 nor this condition holds, `sci` goes to 0 one cycle later.
- R9: `tmr_arm` is 1 exactly when enable bit 0 is set and status bit 0 is clear.
- R10: An APM write of 8'hF1 sets the SCI-enable control bit and 8'hF0 clears it. Any other code leaves it unchanged.
- R11: On every APM write while `cfg_smi_en` is 1, `smi` is high for exactly the following cycle. It never goes high without an APM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_io_base | input | 16 | Window base from configuration space; the low 6 bits are ignored |
| cfg_decode_en | input | 1 | Window decode enable |
| cfg_smi_en | input | 1 | Allows an SMI on APM command writes |
| io_req | input | 1 | I/O access strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Byte address of the access |
| io_size | input | 3 | Access size in bytes (1 to 4) |
| io_wdata | input | 32 | Write data, little-endian |
| io_rdata | output | 32 | Read data, combinational |
| io_hit | output | 1 | Access falls inside the enabled window |
| tmr_ovf_set | input | 1 | Timer overflow event pulse |
| gbl_lock_set | input | 1 | Global-lock release event pulse |
| pwrdn_req | input | 1 | External power-down request pulse |
| rtc_set | input | 1 | RTC alarm event pulse |
| gpe_hp_sts | input | 1 | Hotplug status bit of the general-purpose event block |
| gpe_hp_en | input | 1 | Hotplug enable bit of the general-purpose event block |
| apm_wr | input | 1 | APM command port write strobe |
| apm_data | input | 8 | APM command code |
| sci | output | 1 | Registered level system control interrupt |
| smi | output | 1 | One-cycle SMI pulse |
| sci_en | output | 1 | SCI-enable control bit |
| tmr_arm | output | 1 | Timer overflow may be armed |

## Verification
The SCI path is driven with single enabled sources, pending sources that are not enabled, hotplug status with and without its enable, and a clear that removes the last pending source. Together these show that masking, OR-combining and deassertion are all correct. Window accesses vary in size (one, two and four bytes) and start offset, so the bench can tell a correct little-endian lane mapping from a swapped or truncated one. Out-of-range offsets, a disabled decoder and a relocated base separate real decode from aliasing. APM codes on, off and other are sent with the SMI permission both set and cleared, which shows that the control bit and the SMI pulse are independent.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int REG_W     = 16;
    localparam int REG_BYTES = 2 * (REG_W / 8);

    localparam int TMR_BIT = 0;
    localparam int GBL_BIT = 5;
    localparam int PWR_BIT = 8;
    localparam int RTC_BIT = 10;

    localparam logic [REG_W-1:0] SRC_MASK =
        REG_W'((1 << TMR_BIT) | (1 << GBL_BIT) | (1 << PWR_BIT) | (1 << RTC_BIT));

    localparam logic [7:0] APM_CMD_ON  = 8'hF1;
    localparam logic [7:0] APM_CMD_OFF = 8'hF0;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] en;
    } pm_regs_t;

    typedef struct packed {
        logic ctl_on;
        logic smi;
    } apm_st_t;

endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
    parameter int ADDR_W    = 16,
    parameter int WIN_BITS  = 6,
    parameter int LANES     = 4,
    parameter int REG_BYTES = 4,
    localparam int OFF_W    = WIN_BITS + 1
) (
    input  logic                     io_req,
    input  logic                     io_we,
    input  logic [ADDR_W-1:0]        io_addr,
    input  logic [2:0]               io_size,
    input  logic [8*LANES-1:0]       io_wdata,
    input  logic [ADDR_W-1:0]        cfg_io_base,
    input  logic                     cfg_decode_en,
    output logic                     hit,
    output logic [LANES-1:0]         lane_act,
    output logic [LANES*OFF_W-1:0]   lane_off_flat,
    output logic [REG_BYTES-1:0]     wr_be,
    output logic [8*REG_BYTES-1:0]   wr_byte
);

    localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'((1 << WIN_BITS) - 1);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~WIN_MASK;

    logic [2:0]       size_eff;
    logic [OFF_W-1:0] base_off;
    logic [OFF_W-1:0] lane_off [LANES];

    always_comb begin
        hit      = io_req && cfg_decode_en &&
                   ((io_addr & BASE_MASK) == (cfg_io_base & BASE_MASK));
        size_eff = (io_size > 3'(LANES)) ? 3'(LANES) : io_size;
        base_off = {1'b0, io_addr[WIN_BITS-1:0]};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            lane_off[k] = base_off + OFF_W'(k);
            lane_act[k] = hit && (3'(k) < size_eff);
        end
        assign lane_off_flat[k*OFF_W +: OFF_W] = lane_off[k];
    end

    always_comb begin
        wr_be   = '0;
        wr_byte = '0;
        for (int j = 0; j < REG_BYTES; j++) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_act[k] && io_we && (lane_off[k] == OFF_W'(j))) begin
                    wr_be[j]         = 1'b1;
                    wr_byte[j*8 +: 8] = io_wdata[k*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    localparam int SB = REG_W / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_BYTES-1:0]   wr_be,
    input  logic [8*REG_BYTES-1:0] wr_byte,
    input  logic                   tmr_set,
    input  logic                   gbl_set,
    input  logic                   pwr_set,
    input  logic                   rtc_set,
    output pm_regs_t               regs_q
);

    pm_regs_t         regs_d;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] set_vec;

    always_comb begin
        regs_d  = regs_q;
        clr_vec = '0;
        set_vec = '0;
        for (int b = 0; b < SB; b++) begin
            if (wr_be[b]) begin
                clr_vec[b*8 +: 8] = wr_byte[b*8 +: 8];
            end
            if (wr_be[SB+b]) begin
                regs_d.en[b*8 +: 8] = wr_byte[(SB+b)*8 +: 8];
            end
        end
        set_vec[TMR_BIT] = tmr_set;
        set_vec[GBL_BIT] = gbl_set;
        set_vec[PWR_BIT] = pwr_set;
        set_vec[RTC_BIT] = rtc_set;
        regs_d.sts = ((regs_q.sts & ~clr_vec) | set_vec) & SRC_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/pm_apm_ctl.sv
module pm_apm_ctl
    import pm_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apm_wr,
    input  logic [7:0] apm_data,
    input  logic       cfg_smi_en,
    output logic       ctl_on,
    output logic       smi
);

    apm_st_t st_d;
    apm_st_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smi = apm_wr && cfg_smi_en;
        if (apm_wr) begin
            if (apm_data == APM_CMD_ON) begin
                st_d.ctl_on = 1'b1;
            end else if (apm_data == APM_CMD_OFF) begin
                st_d.ctl_on = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_on = st_q.ctl_on;
    assign smi    = st_q.smi;

endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6,
    parameter int LANES    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_io_base,
    input  logic                cfg_decode_en,
    input  logic                cfg_smi_en,
    input  logic                io_req,
    input  logic                io_we,
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic [2:0]          io_size,
    input  logic [8*LANES-1:0]  io_wdata,
    output logic [8*LANES-1:0]  io_rdata,
    output logic                io_hit,
    input  logic                tmr_ovf_set,
    input  logic                gbl_lock_set,
    input  logic                pwrdn_req,
    input  logic                rtc_set,
    input  logic                gpe_hp_sts,
    input  logic                gpe_hp_en,
    input  logic                apm_wr,
    input  logic [7:0]          apm_data,
    output logic                sci,
    output logic                smi,
    output logic                sci_en,
    output logic                tmr_arm
);

    localparam int OFF_W = WIN_BITS + 1;
    localparam int IDX_W = $clog2(REG_BYTES);

    logic [LANES-1:0]         lane_act;
    logic [LANES*OFF_W-1:0]   lane_off_flat;
    logic [REG_BYTES-1:0]     wr_be;
    logic [8*REG_BYTES-1:0]   wr_byte;
    pm_regs_t                 regs;
    logic [REG_W-1:0]         sts_w;
    logic [REG_W-1:0]         en_w;
    logic [8*REG_BYTES-1:0]   reg_flat;
    logic                     sci_d;
    logic                     sci_q;

    pm_win_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BITS  (WIN_BITS),
        .LANES     (LANES),
        .REG_BYTES (REG_BYTES)
    ) u_dec (
        .io_req        (io_req),
        .io_we         (io_we),
        .io_addr       (io_addr),
        .io_size       (io_size),
        .io_wdata      (io_wdata),
        .cfg_io_base   (cfg_io_base),
        .cfg_decode_en (cfg_decode_en),
        .hit           (io_hit),
        .lane_act      (lane_act),
        .lane_off_flat (lane_off_flat),
        .wr_be         (wr_be),
        .wr_byte       (wr_byte)
    );

    pm_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be   (wr_be),
        .wr_byte (wr_byte),
        .tmr_set (tmr_ovf_set),
        .gbl_set (gbl_lock_set),
        .pwr_set (pwrdn_req),
        .rtc_set (rtc_set),
        .regs_q  (regs)
    );

    pm_apm_ctl u_apm (
        .clk        (clk),
        .rst_n      (rst_n),
        .apm_wr     (apm_wr),
        .apm_data   (apm_data),
        .cfg_smi_en (cfg_smi_en),
        .ctl_on     (sci_en),
        .smi        (smi)
    );

    assign sts_w    = regs.sts;
    assign en_w     = regs.en;
    assign reg_flat = {en_w, sts_w};

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        logic [OFF_W-1:0] off;
        assign off = lane_off_flat[k*OFF_W +: OFF_W];
        always_comb begin
            io_rdata[k*8 +: 8] = '0;
            if (lane_act[k] && !io_we && (off < OFF_W'(REG_BYTES))) begin
                io_rdata[k*8 +: 8] = reg_flat[8*off[IDX_W-1:0] +: 8];
            end
        end
    end

    always_comb begin
        sci_d   = (|(sts_w & en_w & SRC_MASK)) || (gpe_hp_sts && gpe_hp_en);
        tmr_arm = en_w[TMR_BIT] && !sts_w[TMR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sci_q <= 1'b0;
        end else begin
            sci_q <= sci_d;
        end
    end

    assign sci = sci_q;

endmodule

// File: rtl/pm_event_sci_chk.sv
module pm_event_sci_chk
    import pm_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_decode_en,
    input logic             cfg_smi_en,
    input logic             tmr_ovf_set,
    input logic             gpe_hp_sts,
    input logic             gpe_hp_en,
    input logic             apm_wr,
    input logic [7:0]       apm_data,
    input logic [REG_W-1:0] sts_w,
    input logic [REG_W-1:0] en_w,
    input logic             sci,
    input logic             smi,
    input logic             sci_en
);

    AST_SCI_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_w & en_w & SRC_MASK)) |=> sci);  // R7

    AST_SCI_FROM_GPE: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_hp_sts && gpe_hp_en) |=> sci);  // R8

    AST_SCI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(sts_w & en_w & SRC_MASK)) && !(gpe_hp_sts && gpe_hp_en)) |=> !sci);  // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_set |=> sts_w[TMR_BIT]);  // R3

    AST_APM_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_CMD_ON) |=> sci_en);  // R10

    AST_APM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr && apm_data == APM_CMD_OFF) |=> !sci_en);  // R10

    AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> $past(apm_wr && cfg_smi_en));  // R11

    AST_NO_DECODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_decode_en |=> $stable(en_w));  // R6

endmodule

bind pm_event_sci pm_event_sci_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_decode_en (cfg_decode_en),
    .cfg_smi_en    (cfg_smi_en),
    .tmr_ovf_set   (tmr_ovf_set),
    .gpe_hp_sts    (gpe_hp_sts),
    .gpe_hp_en     (gpe_hp_en),
    .apm_wr        (apm_wr),
    .apm_data      (apm_data),
    .sts_w         (sts_w),
    .en_w          (en_w),
    .sci           (sci),
    .smi           (smi),
    .sci_en        (sci_en)
);

// File: tb/pm_event_sci_bench.sv
`timescale 1ns/1ps
module pm_event_sci_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_io_base = 16'hB101;
    logic        cfg_decode_en = 1'b1;
    logic        cfg_smi_en = 1'b0;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [2:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_hit;
    logic        tmr_ovf_set = 1'b0;
    logic        gbl_lock_set = 1'b0;
    logic        pwrdn_req = 1'b0;
    logic        rtc_set = 1'b0;
    logic        gpe_hp_sts = 1'b0;
    logic        gpe_hp_en = 1'b0;
    logic        apm_wr = 1'b0;
    logic [7:0]  apm_data = '0;
    logic        sci, smi, sci_en, tmr_arm;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pm_event_sci u_pm_event_sci (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic [2:0] sz, logic [31:0] d);
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b1; io_addr = a; io_size = sz; io_wdata = d;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0;
    endtask

    task automatic io_read(logic [15:0] a, logic [2:0] sz, output logic [31:0] d,
                           output logic h);
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b0; io_addr = a; io_size = sz;
        #1;
        d = io_rdata; h = io_hit;
        io_req = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic apm_cmd(logic [7:0] code);
        @(negedge clk);
        apm_wr = 1'b1; apm_data = code;
        @(negedge clk);
        apm_wr = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] d; logic h;
        io_read(16'hB100, 3'd4, d, h);
        check("R1 regs after reset", d, 32'h0);
        check("R1 sci/smi/sci_en/tmr_arm", {28'h0, sci, smi, sci_en, tmr_arm}, 32'h0);
    endtask

    task automatic test_set_pulses();
        logic [31:0] d; logic h;
        @(negedge clk); tmr_ovf_set = 1'b1; @(negedge clk); tmr_ovf_set = 1'b0;
        @(negedge clk); gbl_lock_set = 1'b1; @(negedge clk); gbl_lock_set = 1'b0;
        @(negedge clk); pwrdn_req = 1'b1; @(negedge clk); pwrdn_req = 1'b0;
        @(negedge clk); rtc_set = 1'b1; @(negedge clk); rtc_set = 1'b0;
        io_read(16'hB100, 3'd2, d, h);
        check("R2 status after four pulses", d, 32'h0000_0521);
    endtask

    task automatic test_w1c();
        logic [31:0] d; logic h;
        io_write(16'hB100, 3'd2, 32'h0000_0001);
        io_read(16'hB100, 3'd2, d, h);
        check("R3 write-one clears timer bit", d, 32'h0000_0520);
        io_write(16'hB100, 3'd2, 32'h0000_0000);
        io_read(16'hB100, 3'd2, d, h);
        check("R3 write-zero keeps status", d, 32'h0000_0520);
        io_write(16'hB101, 3'd1, 32'h0000_0001);
        io_read(16'hB100, 3'd2, d, h);
        check("R4 byte write at offset 1 clears bit 8", d, 32'h0000_0420);
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b1; io_addr = 16'hB100; io_size = 3'd2;
        io_wdata = 32'h0000_0020; gbl_lock_set = 1'b1;
        @(negedge clk);
        io_req = 1'b0; io_we = 1'b0; gbl_lock_set = 1'b0;
        io_read(16'hB100, 3'd2, d, h);
        check("R3 set pulse beats same-cycle clear", d, 32'h0000_0420);
        io_write(16'hB100, 3'd2, 32'h0000_FFFF);
        io_read(16'hB100, 3'd2, d, h);
        check("R3 clear all", d, 32'h0);
    endtask

    task automatic test_layout();
        logic [31:0] d; logic h;
        io_write(16'hB103, 3'd1, 32'h0000_0004);
        io_read(16'hB100, 3'd4, d, h);
        check("R4 dword read, enable high byte", d, 32'h0400_0000);
        io_write(16'hB102, 3'd2, 32'h0000_0121);
        io_read(16'hB102, 3'd1, d, h);
        check("R4 byte read offset 2 in lane 0", d, 32'h0000_0021);
        io_read(16'hB101, 3'd4, d, h);
        check("R4 dword at offset 1 shifts lanes", d, 32'h0001_2100);
        io_read(16'hB104, 3'd4, d, h);
        check("R5 read beyond registers is zero", d, 32'h0);
        check("R6 offset 4 still inside window", {31'h0, h}, 32'h1);
        io_write(16'hB106, 3'd2, 32'h0000_FFFF);
        io_read(16'hB100, 3'd4, d, h);
        check("R5 write to offset 6 ignored", d, 32'h0121_0000);
    endtask

    task automatic test_sci();
        settle();
        check("R7 no pending source", {31'h0, sci}, 32'h0);
        @(negedge clk); rtc_set = 1'b1; @(negedge clk); rtc_set = 1'b0;
        settle();
        check("R7 pending but not enabled", {31'h0, sci}, 32'h0);
        @(negedge clk); pwrdn_req = 1'b1; @(negedge clk); pwrdn_req = 1'b0;
        settle();
        check("R7 power-down enabled raises sci", {31'h0, sci}, 32'h1);
        io_write(16'hB100, 3'd2, 32'h0000_0100);
        settle();
        check("R7 clear drops sci", {31'h0, sci}, 32'h0);
        io_write(16'hB102, 3'd2, 32'h0000_0400);
        settle();
        check("R7 enabling pending rtc raises sci", {31'h0, sci}, 32'h1);
        io_write(16'hB100, 3'd2, 32'h0000_FFFF);
        settle();
        check("R7 all cleared", {31'h0, sci}, 32'h0);
        @(negedge clk); gpe_hp_sts = 1'b1;
        settle();
        check("R8 gpe status without enable", {31'h0, sci}, 32'h0);
        gpe_hp_en = 1'b1;
        settle(); settle();
        check("R8 gpe status and enable", {31'h0, sci}, 32'h1);
        gpe_hp_sts = 1'b0;
        settle(); settle();
        check("R8 gpe released", {31'h0, sci}, 32'h0);
        gpe_hp_en = 1'b0;
    endtask

    task automatic test_tmr_arm();
        check("R9 arm low with timer disabled", {31'h0, tmr_arm}, 32'h0);
        io_write(16'hB102, 3'd2, 32'h0000_0001);
        check("R9 arm high when enabled and clear", {31'h0, tmr_arm}, 32'h1);
        @(negedge clk); tmr_ovf_set = 1'b1; @(negedge clk); tmr_ovf_set = 1'b0;
        check("R9 arm low while status set", {31'h0, tmr_arm}, 32'h0);
        settle();
        check("R7 timer overflow raises sci", {31'h0, sci}, 32'h1);
        io_write(16'hB100, 3'd1, 32'h0000_0001);
        check("R9 arm back after clear", {31'h0, tmr_arm}, 32'h1);
    endtask

    task automatic test_apm();
        cfg_smi_en = 1'b0;
        apm_cmd(8'hF1);
        check("R10 F1 sets control bit", {31'h0, sci_en}, 32'h1);
        check("R11 no smi while disallowed", {31'h0, smi}, 32'h0);
        apm_cmd(8'h55);
        check("R10 other code keeps control bit", {31'h0, sci_en}, 32'h1);
        cfg_smi_en = 1'b1;
        apm_cmd(8'hF0);
        check("R10 F0 clears control bit", {31'h0, sci_en}, 32'h0);
        check("R11 smi pulse after command", {31'h0, smi}, 32'h1);
        settle();
        check("R11 smi lasts one cycle", {31'h0, smi}, 32'h0);
        apm_cmd(8'h55);
        check("R11 smi on any code", {31'h0, smi}, 32'h1);
        check("R10 other code keeps cleared bit", {31'h0, sci_en}, 32'h0);
        cfg_smi_en = 1'b0;
    endtask

    task automatic test_window();
        logic [31:0] d; logic h;
        cfg_decode_en = 1'b0;
        io_read(16'hB102, 3'd2, d, h);
        check("R6 disabled decode misses", {31'h0, h}, 32'h0);
        check("R6 disabled decode reads zero", d, 32'h0);
        io_write(16'hB102, 3'd2, 32'h0000_FFFF);
        cfg_decode_en = 1'b1;
        io_read(16'hB102, 3'd2, d, h);
        check("R6 write ignored while disabled", d, 32'h0000_0001);
        cfg_io_base = 16'h107F;
        io_read(16'h1042, 3'd2, d, h);
        check("R6 relocated base hits", d, 32'h0000_0001);
        io_read(16'hB102, 3'd2, d, h);
        check("R6 old base misses", {31'h0, h}, 32'h0);
        io_read(16'h1082, 3'd2, d, h);
        check("R6 next 64-byte block misses", {h, d[30:0]}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_set_pulses();
        test_w1c();
        test_layout();
        test_sci();
        test_tmr_arm();
        test_apm();
        test_window();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule